// File: doc/BRIEF.md
# Blitter Rectangle Copy Sequencer

This block turns each point that a drawing engine plots into a rectangular stamp. When stamping is enabled, a single paste request makes the block scan a box inside a source image, one pixel at a time. Each source pixel is fetched through a read request and response port. Its value goes through two XOR stages and an optional transparency test, and the result is written to the destination at a position relative to the paste point. When stamping is disabled, the same request produces one plain pixel write. A line drawer that issues one paste per line pixel therefore paints the line with an arbitrary brush image.

The block deals only in pixel coordinates. The source base address and the raster stride are captured with each request and passed downstream next to every read coordinate. Address arithmetic and bit-plane packing belong to the memory stage that follows. All configuration inputs are sampled when a request is accepted and held for the whole stamp.

Top module: `blit_stamp_seq`

## Requirements
- R1: With stamping disabled, an accepted paste request yields exactly one write, at the paste point, carrying the draw colour, and no reads.
- R2: With stamping enabled, a request issues (W+1)*(H+1) reads, where W and H are the box size inputs. The reads start at the source offset and go in raster order: X rises along a row, and Y rises after a row ends.
- R3: The written colour is (source pixel XOR colour key) XOR draw colour.
- R4: With masking enabled, a pixel whose first-stage XOR result is zero is not written, and all other pixels are written.
- R5: With centring enabled, the stamp's top-left corner is the paste point minus floor((W+1)/2) in X and minus floor((H+1)/2) in Y.
- R6: With centring disabled, the stamp's top-left corner is the paste point.
- R7: The scan includes the far corner: the last read is at source offset plus (W, H).
- R8: A destination write is issued only after the response to its read has arrived. Read and write requests are never raised together, and only one pixel copy is in flight.
- R9: busy rises on the cycle after a request is accepted and stays high until the final write is accepted, or until the final masked response. done then pulses for one cycle while busy is low. req_ready is high only when the block is idle.
- R10: A read or write request that is not accepted keeps its valid signal high and its coordinates and colour unchanged.
- R11: After reset, busy, done, rd_valid and wr_valid are low and req_ready is high.
- R12: Requests issued back to back, as a line drawer does, each produce a complete stamp placed at their own paste point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Paste request present |
| req_ready | output | 1 | Block idle, request will be taken |
| req_x | input | CW | Paste point X |
| req_y | input | CW | Paste point Y |
| req_color | input | PW | Draw colour |
| cfg_enable | input | 1 | 1: stamp a box, 0: single pixel write |
| cfg_mask_en | input | 1 | Skip pixels whose keyed value is zero |
| cfg_center_en | input | 1 | Centre the box on the paste point |
| cfg_color_xor | input | PW | First-stage colour key |
| cfg_box_w | input | BW | Box width minus one |
| cfg_box_h | input | BW | Box height minus one |
| cfg_src_x | input | CW | Source offset X |
| cfg_src_y | input | CW | Source offset Y |
| cfg_src_base | input | AW | Source image base address |
| cfg_src_stride | input | CW | Source raster width in pixels |
| rd_valid | output | 1 | Source read request |
| rd_ready | input | 1 | Read request taken |
| rd_x | output | CW | Source read X |
| rd_y | output | CW | Source read Y |
| rd_base | output | AW | Captured source base |
| rd_stride | output | CW | Captured source stride |
| rsp_valid | input | 1 | Read data returned |
| rsp_data | input | PW | Source pixel value |
| wr_valid | output | 1 | Destination write request |
| wr_ready | input | 1 | Write taken |
| wr_x | output | CW | Destination X |
| wr_y | output | CW | Destination Y |
| wr_color | output | PW | Pixel value to write |
| busy | output | 1 | Stamp in progress |
| done | output | 1 | One-cycle pulse at stamp end |

## Verification
On every cycle the checker verifies the handshake side: read and write requests never overlap, stalled requests hold their payload, done is a single pulse that follows the fall of busy, and a request with stamping disabled leads straight to one write at the paste point. A request with stamping enabled is checked to open with a read at the source offset. The rest can only be shown by the bench's scenarios, which compare against a model image: the full raster read order, the colour arithmetic, which pixels the mask drops, the centred and uncentred placement, and the far-corner pixel.

// File: rtl/blit_pkg.sv
package blit_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_READ  = 2'd1,
      ST_WAIT  = 2'd2,
      ST_WRITE = 2'd3
   } blit_state_e;
endpackage

// File: rtl/blit_scan_ctr.sv
// Raster walker over an inclusive box [0..lim_w] x [0..lim_h].
module blit_scan_ctr #(
   parameter int BW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear,
   input  logic          step,
   input  logic [BW-1:0] lim_w,
   input  logic [BW-1:0] lim_h,
   output logic [BW-1:0] cx,
   output logic [BW-1:0] cy,
   output logic          last
);
   logic row_end;

   assign row_end = (cx == lim_w);
   assign last    = row_end && (cy == lim_h);

   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         cx <= '0;
         cy <= '0;
      end else if (step && !last) begin
         if (row_end) begin
            cx <= '0;
            cy <= cy + 1'b1;
         end else begin
            cx <= cx + 1'b1;
         end
      end
   end
endmodule

// File: rtl/blit_pixel_xform.sv
// Two-stage colour XOR with optional transparency on a zero keyed value.
module blit_pixel_xform #(
   parameter int PW       = 8,
   parameter bit HAS_MASK = 1'b1
) (
   input  logic [PW-1:0] src,
   input  logic [PW-1:0] key,
   input  logic [PW-1:0] draw,
   input  logic          mask_en,
   output logic [PW-1:0] pix,
   output logic          skip
);
   logic [PW-1:0] keyed;

   assign keyed = src ^ key;
   assign pix   = keyed ^ draw;

   generate
      if (HAS_MASK) begin : g_mask
         assign skip = mask_en && (keyed == '0);
      end else begin : g_nomask
         assign skip = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/blit_dest_place.sv
// Top-left corner of the destination stamp.
module blit_dest_place #(
   parameter int CW         = 12,
   parameter int BW         = 8,
   parameter bit HAS_CENTER = 1'b1
) (
   input  logic [CW-1:0] px,
   input  logic [CW-1:0] py,
   input  logic [BW-1:0] box_w,
   input  logic [BW-1:0] box_h,
   input  logic          center_en,
   output logic [CW-1:0] ox,
   output logic [CW-1:0] oy
);
   localparam int HW = BW + 1;

   generate
      if (HAS_CENTER) begin : g_center
         logic [HW-1:0] half_w, half_h;
         assign half_w = ({1'b0, box_w} + HW'(1)) >> 1;
         assign half_h = ({1'b0, box_h} + HW'(1)) >> 1;
         assign ox = center_en ? (px - CW'(half_w)) : px;
         assign oy = center_en ? (py - CW'(half_h)) : py;
      end else begin : g_corner
         logic unused_c;
         assign unused_c = center_en ^ (^box_w) ^ (^box_h);
         assign ox = px;
         assign oy = py;
      end
   endgenerate
endmodule

// File: rtl/blit_stamp_seq.sv
module blit_stamp_seq
   import blit_pkg::*;
#(
   parameter int CW         = 12,
   parameter int PW         = 8,
   parameter int BW         = 8,
   parameter int AW         = 20,
   parameter bit HAS_MASK   = 1'b1,
   parameter bit HAS_CENTER = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   output logic          req_ready,
   input  logic [CW-1:0] req_x,
   input  logic [CW-1:0] req_y,
   input  logic [PW-1:0] req_color,
   input  logic          cfg_enable,
   input  logic          cfg_mask_en,
   input  logic          cfg_center_en,
   input  logic [PW-1:0] cfg_color_xor,
   input  logic [BW-1:0] cfg_box_w,
   input  logic [BW-1:0] cfg_box_h,
   input  logic [CW-1:0] cfg_src_x,
   input  logic [CW-1:0] cfg_src_y,
   input  logic [AW-1:0] cfg_src_base,
   input  logic [CW-1:0] cfg_src_stride,
   output logic          rd_valid,
   input  logic          rd_ready,
   output logic [CW-1:0] rd_x,
   output logic [CW-1:0] rd_y,
   output logic [AW-1:0] rd_base,
   output logic [CW-1:0] rd_stride,
   input  logic          rsp_valid,
   input  logic [PW-1:0] rsp_data,
   output logic          wr_valid,
   input  logic          wr_ready,
   output logic [CW-1:0] wr_x,
   output logic [CW-1:0] wr_y,
   output logic [PW-1:0] wr_color,
   output logic          busy,
   output logic          done
);
   initial begin
      assert (BW <= CW) else $error("box counter wider than coordinates");
      assert (PW >= 1 && CW >= 2 && AW >= 1) else $error("bad widths");
   end

   blit_state_e st;

   logic          en_q, mk_q, ce_q;
   logic [CW-1:0] px_q, py_q, sx_q, sy_q, stride_q;
   logic [PW-1:0] col_q, key_q, pix_q;
   logic [BW-1:0] w_q, h_q;
   logic [AW-1:0] base_q;
   logic          done_q;

   logic          accept, step, finish, last, last_eff;
   logic [BW-1:0] cx, cy;
   logic [CW-1:0] ox, oy;
   logic [PW-1:0] xf_pix;
   logic          xf_skip;
   logic          rsp_take;

   assign accept   = req_valid && (st == ST_IDLE);
   assign rsp_take = (st == ST_WAIT) && rsp_valid;
   assign last_eff = !en_q || last;
   assign step     = (rsp_take && xf_skip) ||
                     ((st == ST_WRITE) && wr_ready && en_q);
   assign finish   = last_eff && ((rsp_take && xf_skip) ||
                                  ((st == ST_WRITE) && wr_ready));

   blit_scan_ctr #(.BW(BW)) u_scan (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (accept),
      .step  (step),
      .lim_w (w_q),
      .lim_h (h_q),
      .cx    (cx),
      .cy    (cy),
      .last  (last)
   );

   blit_pixel_xform #(.PW(PW), .HAS_MASK(HAS_MASK)) u_xform (
      .src     (rsp_data),
      .key     (key_q),
      .draw    (col_q),
      .mask_en (mk_q),
      .pix     (xf_pix),
      .skip    (xf_skip)
   );

   blit_dest_place #(.CW(CW), .BW(BW), .HAS_CENTER(HAS_CENTER)) u_place (
      .px        (px_q),
      .py        (py_q),
      .box_w     (w_q),
      .box_h     (h_q),
      .center_en (ce_q),
      .ox        (ox),
      .oy        (oy)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         en_q     <= 1'b0;
         mk_q     <= 1'b0;
         ce_q     <= 1'b0;
         px_q     <= '0;
         py_q     <= '0;
         sx_q     <= '0;
         sy_q     <= '0;
         stride_q <= '0;
         col_q    <= '0;
         key_q    <= '0;
         pix_q    <= '0;
         w_q      <= '0;
         h_q      <= '0;
         base_q   <= '0;
         done_q   <= 1'b0;
      end else begin
         done_q <= finish;
         unique case (st)
            ST_IDLE: begin
               if (accept) begin
                  en_q     <= cfg_enable;
                  mk_q     <= cfg_mask_en;
                  ce_q     <= cfg_center_en;
                  px_q     <= req_x;
                  py_q     <= req_y;
                  col_q    <= req_color;
                  key_q    <= cfg_color_xor;
                  w_q      <= cfg_box_w;
                  h_q      <= cfg_box_h;
                  sx_q     <= cfg_src_x;
                  sy_q     <= cfg_src_y;
                  base_q   <= cfg_src_base;
                  stride_q <= cfg_src_stride;
                  st       <= cfg_enable ? ST_READ : ST_WRITE;
               end
            end
            ST_READ: begin
               if (rd_ready) st <= ST_WAIT;
            end
            ST_WAIT: begin
               if (rsp_valid) begin
                  pix_q <= xf_pix;
                  if (xf_skip) st <= last ? ST_IDLE : ST_READ;
                  else         st <= ST_WRITE;
               end
            end
            ST_WRITE: begin
               if (wr_ready) st <= last_eff ? ST_IDLE : ST_READ;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign req_ready = (st == ST_IDLE);
   assign busy      = (st != ST_IDLE);
   assign done      = done_q;

   assign rd_valid  = (st == ST_READ);
   assign rd_x      = sx_q + CW'(cx);
   assign rd_y      = sy_q + CW'(cy);
   assign rd_base   = base_q;
   assign rd_stride = stride_q;

   assign wr_valid  = (st == ST_WRITE);
   assign wr_x      = en_q ? (ox + CW'(cx)) : px_q;
   assign wr_y      = en_q ? (oy + CW'(cy)) : py_q;
   assign wr_color  = en_q ? pix_q : col_q;
endmodule

// File: rtl/blit_stamp_seq_chk.sv
module blit_stamp_seq_chk #(
   parameter int CW = 12,
   parameter int PW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          req_valid,
   input logic          req_ready,
   input logic [CW-1:0] req_x,
   input logic [CW-1:0] req_y,
   input logic [PW-1:0] req_color,
   input logic          cfg_enable,
   input logic [CW-1:0] cfg_src_x,
   input logic [CW-1:0] cfg_src_y,
   input logic          rd_valid,
   input logic          rd_ready,
   input logic [CW-1:0] rd_x,
   input logic [CW-1:0] rd_y,
   input logic          wr_valid,
   input logic          wr_ready,
   input logic [CW-1:0] wr_x,
   input logic [CW-1:0] wr_y,
   input logic [PW-1:0] wr_color,
   input logic          busy,
   input logic          done
);
   // R8: one copy in flight, read and write never overlap
   p_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_valid && wr_valid));

   // R10: stalled write holds its payload
   p_wr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_x) && $stable(wr_y) && $stable(wr_color)));

   // R10: stalled read holds its coordinates
   p_rd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_x) && $stable(rd_y)));

   // R9: done is a single pulse
   p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R9: end of busy is marked by done
   p_busy_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);

   // R1: disabled stamping writes the paste point with draw colour
   p_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && !cfg_enable) |=>
         (wr_valid && wr_x == $past(req_x) && wr_y == $past(req_y) && wr_color == $past(req_color)));

   // R2: enabled stamping opens with a read at the source offset
   p_first_rd_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && cfg_enable) |=>
         (rd_valid && rd_x == $past(cfg_src_x) && rd_y == $past(cfg_src_y)));
endmodule

bind blit_stamp_seq blit_stamp_seq_chk #(.CW(CW), .PW(PW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .req_ready  (req_ready),
   .req_x      (req_x),
   .req_y      (req_y),
   .req_color  (req_color),
   .cfg_enable (cfg_enable),
   .cfg_src_x  (cfg_src_x),
   .cfg_src_y  (cfg_src_y),
   .rd_valid   (rd_valid),
   .rd_ready   (rd_ready),
   .rd_x       (rd_x),
   .rd_y       (rd_y),
   .wr_valid   (wr_valid),
   .wr_ready   (wr_ready),
   .wr_x       (wr_x),
   .wr_y       (wr_y),
   .wr_color   (wr_color),
   .busy       (busy),
   .done       (done)
);

// File: tb/blit_stamp_seq_bench.sv
module blit_stamp_seq_bench;
   localparam int CW = 12;
   localparam int PW = 8;
   localparam int BW = 8;
   localparam int AW = 20;

   typedef struct packed {
      logic       en;
      logic       mk;
      logic       ce;
      logic [2:0] w;
      logic [2:0] h;
      logic [7:0] sx;
      logic [7:0] sy;
      logic [7:0] xr;
      logic [11:0] px;
      logic [11:0] py;
      logic [7:0] col;
   } vec_t;

   // 0: R1 single write; 1: R3 R6 plain copy; 2: R4 masked; 3: R5 centred+mask;
   // 4: 1x1 centred; 5: R7 one-row centred masked box
   localparam vec_t VEC [0:5] = '{
      '{1'b0, 1'b0, 1'b1, 3'd2, 3'd2, 8'd0, 8'd0, 8'h00, 12'd30, 12'd40, 8'h5A},
      '{1'b1, 1'b0, 1'b0, 3'd2, 3'd1, 8'd0, 8'd0, 8'h00, 12'd10, 12'd20, 8'h00},
      '{1'b1, 1'b1, 1'b0, 3'd3, 3'd2, 8'd1, 8'd2, 8'h00, 12'd5,  12'd6,  8'h10},
      '{1'b1, 1'b1, 1'b1, 3'd3, 3'd3, 8'd2, 8'd0, 8'h01, 12'd20, 12'd20, 8'h40},
      '{1'b1, 1'b0, 1'b1, 3'd0, 3'd0, 8'd3, 8'd3, 8'h03, 12'd7,  12'd9,  8'h80},
      '{1'b1, 1'b1, 1'b1, 3'd2, 3'd0, 8'd4, 8'd5, 8'h02, 12'd1,  12'd1,  8'h20}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic [CW-1:0] req_x = '0, req_y = '0;
   logic [PW-1:0] req_color = '0;
   logic          cfg_enable = 1'b0, cfg_mask_en = 1'b0, cfg_center_en = 1'b0;
   logic [PW-1:0] cfg_color_xor = '0;
   logic [BW-1:0] cfg_box_w = '0, cfg_box_h = '0;
   logic [CW-1:0] cfg_src_x = '0, cfg_src_y = '0, cfg_src_stride = 12'd320;
   logic [AW-1:0] cfg_src_base = 20'h01200;
   logic          rd_valid, rd_ready = 1'b1;
   logic [CW-1:0] rd_x, rd_y, rd_stride;
   logic [AW-1:0] rd_base;
   logic          rsp_valid = 1'b0;
   logic [PW-1:0] rsp_data = '0;
   logic          wr_valid, wr_ready = 1'b1;
   logic [CW-1:0] wr_x, wr_y;
   logic [PW-1:0] wr_color;
   logic          busy, done;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   blit_stamp_seq u_blit_stamp_seq (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready),
      .req_x(req_x), .req_y(req_y), .req_color(req_color),
      .cfg_enable(cfg_enable), .cfg_mask_en(cfg_mask_en), .cfg_center_en(cfg_center_en),
      .cfg_color_xor(cfg_color_xor), .cfg_box_w(cfg_box_w), .cfg_box_h(cfg_box_h),
      .cfg_src_x(cfg_src_x), .cfg_src_y(cfg_src_y),
      .cfg_src_base(cfg_src_base), .cfg_src_stride(cfg_src_stride),
      .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_x(rd_x), .rd_y(rd_y),
      .rd_base(rd_base), .rd_stride(rd_stride),
      .rsp_valid(rsp_valid), .rsp_data(rsp_data),
      .wr_valid(wr_valid), .wr_ready(wr_ready),
      .wr_x(wr_x), .wr_y(wr_y), .wr_color(wr_color),
      .busy(busy), .done(done)
   );

   function automatic logic [PW-1:0] img(input logic [CW-1:0] x, input logic [CW-1:0] y);
      return {6'b0, x[1:0] ^ y[1:0]};
   endfunction

   // Recorded traffic
   logic [CW-1:0] rec_rx [0:63];
   logic [CW-1:0] rec_ry [0:63];
   logic [CW-1:0] rec_wx [0:63];
   logic [CW-1:0] rec_wy [0:63];
   logic [PW-1:0] rec_wc [0:63];
   int rd_n = 0;
   int wr_n = 0;
   bit pend = 1'b0;
   logic [PW-1:0] pdata = '0;

   // Responder (one-cycle latency) and monitor, both off the active edge
   initial begin
      forever begin
         @(negedge clk);
         rsp_valid = 1'b0;
         if (pend) begin
            rsp_valid = 1'b1;
            rsp_data  = pdata;
            pend      = 1'b0;
         end
         if (rd_valid && rd_ready) begin
            pend  = 1'b1;
            pdata = img(rd_x, rd_y);
            if (rd_n < 64) begin
               rec_rx[rd_n] = rd_x;
               rec_ry[rd_n] = rd_y;
            end
            rd_n++;
         end
         if (wr_valid && wr_ready) begin
            if (wr_n < 64) begin
               rec_wx[wr_n] = wr_x;
               rec_wy[wr_n] = wr_y;
               rec_wc[wr_n] = wr_color;
            end
            wr_n++;
         end
      end
   end

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   endtask

   task automatic paste(input logic [CW-1:0] x, input logic [CW-1:0] y, input logic [PW-1:0] c);
      int t = 0;
      @(negedge clk);
      req_valid = 1'b1; req_x = x; req_y = y; req_color = c;
      @(negedge clk);
      req_valid = 1'b0;
      check(busy == 1'b1 && req_ready == 1'b0, "R9", "busy after accept", busy, 1);
      while (!done && t < 2000) begin
         @(negedge clk);
         t++;
      end
      check(done == 1'b1 && busy == 1'b0, "R9", "done pulse with busy low", {done, busy}, 2'b10);
   endtask

   task automatic run_vec(input vec_t v, input int id);
      logic [CW-1:0] ex [0:63];
      logic [CW-1:0] ey [0:63];
      logic [PW-1:0] ec [0:63];
      logic [CW-1:0] erx [0:63];
      logic [CW-1:0] ery [0:63];
      int ne = 0;
      int nr = 0;
      bit ok;
      logic [CW-1:0] ox, oy;
      logic [PW-1:0] p1;
      string rq;
      cfg_enable    = v.en;
      cfg_mask_en   = v.mk;
      cfg_center_en = v.ce;
      cfg_box_w     = {5'b0, v.w};
      cfg_box_h     = {5'b0, v.h};
      cfg_src_x     = {4'b0, v.sx};
      cfg_src_y     = {4'b0, v.sy};
      cfg_color_xor = v.xr;
      rd_n = 0;
      wr_n = 0;
      paste(v.px, v.py, v.col);

      if (!v.en) begin
         ex[0] = v.px; ey[0] = v.py; ec[0] = v.col; ne = 1;
      end else begin
         ox = v.ce ? v.px - CW'((v.w + 4'd1) >> 1) : v.px;   // R5 / R6
         oy = v.ce ? v.py - CW'((v.h + 4'd1) >> 1) : v.py;
         for (int yy = 0; yy <= int'(v.h); yy++) begin
            for (int xx = 0; xx <= int'(v.w); xx++) begin
               erx[nr] = CW'(v.sx) + CW'(xx);
               ery[nr] = CW'(v.sy) + CW'(yy);
               p1 = img(erx[nr], ery[nr]) ^ v.xr;
               nr++;
               if (!(v.mk && p1 == '0)) begin
                  ex[ne] = ox + CW'(xx);
                  ey[ne] = oy + CW'(yy);
                  ec[ne] = p1 ^ v.col;
                  ne++;
               end
            end
         end
      end

      rq = !v.en ? "R1" : (v.mk ? "R4" : (v.ce ? "R5" : "R3"));
      check(rd_n == nr, v.en ? "R2" : "R1", $sformatf("vec%0d read count", id), rd_n, nr);
      ok = 1'b1;
      for (int i = 0; i < nr && i < rd_n; i++)
         if (rec_rx[i] != erx[i] || rec_ry[i] != ery[i]) ok = 1'b0;
      check(ok, "R2", $sformatf("vec%0d raster read order", id), 0, 0);
      if (v.en && rd_n > 0)
         check(rec_rx[rd_n-1] == erx[nr-1] && rec_ry[rd_n-1] == ery[nr-1], "R7",
               $sformatf("vec%0d last read", id), {rec_rx[rd_n-1], rec_ry[rd_n-1]},
               {erx[nr-1], ery[nr-1]});
      check(wr_n == ne, rq, $sformatf("vec%0d write count", id), wr_n, ne);
      ok = 1'b1;
      for (int i = 0; i < ne && i < wr_n; i++)
         if (rec_wx[i] != ex[i] || rec_wy[i] != ey[i] || rec_wc[i] != ec[i]) begin
            if (ok) check(1'b0, rq, $sformatf("vec%0d write %0d", id, i),
                          {rec_wx[i], rec_wy[i], rec_wc[i]}, {ex[i], ey[i], ec[i]});
            ok = 1'b0;
         end
      if (ok) check(1'b1, rq, "writes", 0, 0);
   endtask

   // Watchdog
   initial begin
      #1500000;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      finish_run();
   end

   initial begin
      vec_t lv;
      logic [CW-1:0] hx;
      logic [PW-1:0] hc;
      bit held;
      repeat (3) @(negedge clk);
      // R11: reset state
      check(busy == 1'b0, "R11", "busy in reset", busy, 0);
      check(done == 1'b0, "R11", "done in reset", done, 0);
      check(rd_valid == 1'b0 && wr_valid == 1'b0, "R11", "requests in reset", {rd_valid, wr_valid}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(req_ready == 1'b1 && busy == 1'b0, "R11", "idle after reset", {req_ready, busy}, 2'b10);
      check(rd_base == 20'h0 && rd_stride == 12'h0, "R11", "captured raster fields", rd_base, 0);

      for (int i = 0; i < 6; i++) run_vec(VEC[i], i);
      check(rd_base == cfg_src_base && rd_stride == cfg_src_stride, "R2",
            "raster fields passed downstream", rd_stride, cfg_src_stride);

      // R12: line drawer style back-to-back stamps at adjacent points
      for (int k = 0; k < 3; k++) begin
         lv = '{1'b1, 1'b0, 1'b1, 3'd1, 3'd1, 8'd0, 8'd1, 8'h00,
                12'd50 + 12'(k), 12'd60 + 12'(k), 8'h30};
         run_vec(lv, 10 + k);
      end

      // R10 / R8: stalled write holds its payload; no read while a write waits
      cfg_enable = 1'b1; cfg_mask_en = 1'b0; cfg_center_en = 1'b0;
      cfg_box_w = 8'd0; cfg_box_h = 8'd0; cfg_src_x = 12'd1; cfg_src_y = 12'd0;
      cfg_color_xor = 8'h00;
      wr_ready = 1'b0;
      @(negedge clk);
      req_valid = 1'b1; req_x = 12'd100; req_y = 12'd101; req_color = 8'h04;
      @(negedge clk);
      req_valid = 1'b0;
      while (!wr_valid) @(negedge clk);
      hx = wr_x; hc = wr_color;
      held = 1'b1;
      repeat (3) begin
         @(negedge clk);
         if (!wr_valid || wr_x != hx || wr_color != hc || rd_valid) held = 1'b0;
      end
      check(held, "R10", "write held under stall", {wr_x, wr_color}, {hx, hc});
      check(hx == 12'd100 && hc == 8'h05, "R8", "write after response", {hx, hc}, {12'd100, 8'h05});
      wr_ready = 1'b1;
      while (!done) @(negedge clk);
      check(busy == 1'b0, "R9", "idle after stalled stamp", busy, 0);

      finish_run();
   end
endmodule